// File: doc/BRIEF.md
# Vector High-Half Narrowing Add/Subtract Unit

This unit takes two 128-bit source operands holding wide integer elements. It adds or subtracts them lane by lane, with optional round-to-nearest, and keeps the most significant half of each wide result. The narrowed lanes are packed into 64 bits of a 128-bit destination value. A two-bit size code picks the narrow element width: 8, 16 or 32 bits. The wide source elements are twice that width, so every legal size fills exactly 64 bits of narrow results.

Two placement modes are available. In the lower mode the packed results land in bits 63:0 and the upper half of the destination is cleared. In the upper mode the results land in bits 127:64, and the lower half is copied unchanged from the current destination value, which the caller presents on `dst_old`.

A request is accepted when `in_valid` is high. The new destination appears one clock later, registered, together with a one-cycle `out_valid` pulse.

Top module: `hn_narrow_top`

## Requirements
- R1: During and right after synchronous active-low reset, `dst_new` is all zeros and `out_valid` and `illegal` are low.
- R2: Size code 0, 1 and 2 select narrow widths of 8, 16 and 32 bits, giving 8, 4 and 2 lanes. Lane 0 occupies the least significant bits of every operand, and lanes are packed contiguously in ascending order.
- R3: With `op_sub`=0 and no rounding, each narrow lane equals the upper half of (a + b) taken modulo 2^(2·width), so a carry out of the wide lane is dropped.
- R4: With `op_sub`=1 and no rounding, each narrow lane equals the upper half of (a − b) taken modulo 2^(2·width), so a borrow wraps around.
- R5: With `rnd_en`=1, the value 2^(width−1) is added to the wide sum or difference before the upper half is taken, again modulo 2^(2·width).
- R6: With `hi_sel`=0 and a legal size, the packed lanes go to bits 63:0 of `dst_new` and bits 127:64 are zero.
- R7: With `hi_sel`=1 and a legal size, the packed lanes go to bits 127:64 of `dst_new` and bits 63:0 equal `dst_old[63:0]`.
- R8: Size code 3 is reserved. An accepted request with it sets `illegal`=1 and makes `dst_new` equal `dst_old`.
- R9: The result and `illegal` are registered. They change on the clock edge that accepts `in_valid`=1, and `out_valid` is high exactly in the cycle after an accepted request.
- R10: While `in_valid` is low, `dst_new` and `illegal` keep their values regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | First wide-element operand |
| src_b | input | 128 | Second wide-element operand |
| dst_old | input | 128 | Current destination value |
| size_code | input | 2 | Narrow width: 0=8, 1=16, 2=32, 3=reserved |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| rnd_en | input | 1 | 1 = add rounding constant before narrowing |
| hi_sel | input | 1 | 0 = write lower half, 1 = write upper half |
| out_valid | output | 1 | Result valid, one cycle after request |
| dst_new | output | 128 | New destination value |
| illegal | output | 1 | Last accepted request used the reserved size |

## Verification
The assertions check the placement rules on every cycle: cleared upper half in lower mode, preserved lower half in upper mode, and pass-through of `dst_old` on the reserved size. They also check the one-cycle valid timing and the holding of outputs while idle. The numeric content of each lane cannot be checked by these properties: carry and borrow wraparound, the rounding constant, and the lane order for each size. Those are shown only by the bench's scenarios, which compare against a 128-bit integer reference using all-ones, all-zeros, borrow-producing and pseudo-random operands in every mode.

// File: rtl/hn_pkg.sv
// Package: shared constants and the element size encoding for the
// high-half narrowing unit. Assumes a lane base width of 8 bits.
package hn_pkg;
    localparam int LANE_BASE = 8;   // narrowest result element, bits
    localparam int NUM_SIZES = 3;   // legal size codes 0..2

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_RSV = 2'd3
    } hn_size_e;
endpackage

// File: rtl/hn_lane.sv
// Module: one wide lane. Adds or subtracts two 2*NW-bit elements, wraps
// modulo 2^(2*NW), optionally adds the rounding half-unit, and returns
// the upper NW bits. Purely combinational.
module hn_lane #(
    parameter int NW = 8
) (
    input  logic [2*NW-1:0] a,
    input  logic [2*NW-1:0] b,
    input  logic            sub,
    input  logic            rnd,
    output logic [NW-1:0]   q
);
    localparam int WW = 2 * NW;

    logic [WW-1:0] rnd_const;
    logic [WW-1:0] core;
    logic [WW-1:0] total;

    // Form the wrapped wide result and keep its most significant half.
    always_comb begin
        rnd_const = rnd ? (WW'(1) << (NW - 1)) : '0;
        core      = sub ? (a - b) : (a + b);
        total     = core + rnd_const;
        q         = total[WW-1:NW];
    end
endmodule

// File: rtl/hn_place.sv
// Module: picks the packed narrow results for the requested size and
// places them in the lower or upper half of the destination. The
// reserved size passes the old destination through and flags it.
module hn_place #(
    parameter int DATA_W = 128
) (
    input  logic [hn_pkg::NUM_SIZES-1:0][DATA_W/2-1:0] narrow,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [1:0]        size_code,
    input  logic              hi_sel,
    output logic [DATA_W-1:0] next_dst,
    output logic              next_illegal
);
    import hn_pkg::*;
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] chosen;

    // Select the packed lanes that belong to the requested size.
    always_comb begin
        next_illegal = 1'b0;
        chosen       = '0;
        unique case (hn_size_e'(size_code))
            SZ_8:    chosen = narrow[0];
            SZ_16:   chosen = narrow[1];
            SZ_32:   chosen = narrow[2];
            default: next_illegal = 1'b1;
        endcase
    end

    // Place the chosen lanes according to the half select.
    always_comb begin
        if (next_illegal)
            next_dst = dst_old;
        else if (hi_sel)
            next_dst = {chosen, dst_old[HALF_W-1:0]};
        else
            next_dst = {{HALF_W{1'b0}}, chosen};
    end
endmodule

// File: rtl/hn_narrow_top.sv
// Module: top of the high-half narrowing add/subtract unit. Builds the
// lanes for every legal size in parallel, selects and places one set,
// and registers the result. Assumes DATA_W is a multiple of 128 so that
// every size fills the half width with whole lanes.
module hn_narrow_top #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [1:0]        size_code,
    input  logic              op_sub,
    input  logic              rnd_en,
    input  logic              hi_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] dst_new,
    output logic              illegal
);
    import hn_pkg::*;
    localparam int HALF_W = DATA_W / 2;

    logic [NUM_SIZES-1:0][HALF_W-1:0] narrow;
    logic [DATA_W-1:0]                next_dst;
    logic                             next_illegal;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int NW = LANE_BASE << s;
        localparam int NL = HALF_W / NW;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            hn_lane #(.NW(NW)) u_lane (
                .a   (src_a[i*2*NW +: 2*NW]),
                .b   (src_b[i*2*NW +: 2*NW]),
                .sub (op_sub),
                .rnd (rnd_en),
                .q   (narrow[s][i*NW +: NW])
            );
        end
    end

    hn_place #(.DATA_W(DATA_W)) u_place (
        .narrow       (narrow),
        .dst_old      (dst_old),
        .size_code    (size_code),
        .hi_sel       (hi_sel),
        .next_dst     (next_dst),
        .next_illegal (next_illegal)
    );

    // Register the result on each accepted request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_new   <= '0;
            illegal   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_new <= next_dst;
                illegal <= next_illegal;
            end
        end
    end
endmodule

// File: rtl/hn_narrow_chk.sv
// Module: property checker for hn_narrow_top, bound to every instance.
// Checks placement, reserved-size handling and timing at the ports.
module hn_narrow_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] dst_old,
    input logic [1:0]        size_code,
    input logic              hi_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] dst_new,
    input logic              illegal
);
    localparam int HALF_W = DATA_W / 2;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !illegal && dst_new == '0));

    p_lower_clears_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code != 2'd3 && !hi_sel) |=> dst_new[DATA_W-1:HALF_W] == '0);

    p_upper_keeps_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code != 2'd3 && hi_sel)
        |=> dst_new[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]));

    p_reserved_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'd3) |=> (illegal && dst_new == $past(dst_old)));

    p_legal_not_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code != 2'd3) |=> !illegal);

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(dst_new) && $stable(illegal)));
endmodule

bind hn_narrow_top hn_narrow_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dst_old   (dst_old),
    .size_code (size_code),
    .hi_sel    (hi_sel),
    .out_valid (out_valid),
    .dst_new   (dst_new),
    .illegal   (illegal)
);

// File: tb/sim_hn_narrow_top.sv
// Bench: behavioural 128-bit reference model, compared each cycle.
module sim_hn_narrow_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [1:0]   size_code = '0;
    logic         op_sub = 1'b0, rnd_en = 1'b0, hi_sel = 1'b0;
    logic         out_valid, illegal;
    logic [127:0] dst_new;

    int checks = 0;
    int fails  = 0;
    logic [127:0] exp_dst = '0;
    logic         exp_ill = 1'b0;

    always #5 clk = ~clk;

    hn_narrow_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
        .src_b(src_b), .dst_old(dst_old), .size_code(size_code),
        .op_sub(op_sub), .rnd_en(rnd_en), .hi_sel(hi_sel),
        .out_valid(out_valid), .dst_new(dst_new), .illegal(illegal)
    );

    // Reference: wide arithmetic on integers per lane, then placement.
    function automatic logic [128:0] model(
        input logic [127:0] a, input logic [127:0] b, input logic [127:0] d,
        input int sz, input bit sub, input bit rnd, input bit hi);
        logic [127:0] res, mask, wa, wb, r, packed_q;
        int e, n;
        if (sz == 3) return {1'b1, d};
        e = 8 << sz;
        n = 8 >> sz;
        mask = (128'd1 << (2 * e)) - 128'd1;
        packed_q = '0;
        for (int i = 0; i < n; i++) begin
            wa = (a >> (i * 2 * e)) & mask;
            wb = (b >> (i * 2 * e)) & mask;
            r  = sub ? wa - wb : wa + wb;
            if (rnd) r = r + (128'd1 << (e - 1));
            r  = (r & mask) >> e;
            packed_q = packed_q | (r << (i * e));
        end
        res = hi ? {packed_q[63:0], d[63:0]} : {64'd0, packed_q[63:0]};
        return {1'b0, res};
    endfunction

    task automatic check(input string tag, input logic [127:0] got,
                         input logic [127:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    // Apply one request at a negedge; check at the following negedge.
    task automatic run(input string tag, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] d,
                       input int sz, input bit sub, input bit rnd, input bit hi);
        logic [128:0] m;
        m = model(a, b, d, sz, sub, rnd, hi);
        src_a = a; src_b = b; dst_old = d; size_code = 2'(sz);
        op_sub = sub; rnd_en = rnd; hi_sel = hi; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_dst = m[127:0];
        exp_ill = m[128];
        check(tag, dst_new, exp_dst);
        check({tag, " illegal"}, {127'd0, illegal}, {127'd0, exp_ill});
        check("R9 out_valid", {127'd0, out_valid}, 128'd1);
    endtask

    logic [127:0] ones = '1;
    logic [127:0] pat_d = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 dst", dst_new, '0);
        check("R1 flags", {126'd0, out_valid, illegal}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int sz = 0; sz < 3; sz++) begin
            // R3 carry wraps: all-ones plus all-ones
            run("R3 add ones", ones, ones, pat_d, sz, 0, 0, 0);
            // R4 borrow wraps: zero minus one per lane
            run("R4 sub borrow", '0, {16{8'h01}}, pat_d, sz, 1, 0, 0);
            // R5 rounding carries across the half boundary
            run("R5 round add", ones, '0, pat_d, sz, 0, 1, 0);
            run("R5 round sub", '0, '0, pat_d, sz, 1, 1, 1);
            // R6 lower mode clears the top
            run("R6 lower", pat_d, ~pat_d, ones, sz, 0, 0, 0);
            // R7 upper mode keeps the old low half
            run("R7 upper", pat_d, ~pat_d, pat_d, sz, 1, 1, 1);
        end

        // R2 lane order: distinct values per wide lane, all sizes
        for (int sz = 0; sz < 3; sz++)
            run("R2 lane order", 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0,
                128'h0001_0002_0003_0004_0005_0006_0007_0008, '0, sz, 0, 0, 0);

        // R8 reserved size passes the old destination through
        run("R8 reserved", ones, ones, pat_d, 3, 0, 1, 1);
        run("R8 cleared after legal", ones, '0, pat_d, 0, 0, 0, 0);

        // R10 hold while idle: change every input, keep in_valid low
        src_a = ~src_a; src_b = ~src_b; dst_old = ~dst_old;
        size_code = 2'd3; hi_sel = ~hi_sel;
        @(negedge clk);
        check("R10 hold dst", dst_new, exp_dst);
        check("R10 hold illegal", {127'd0, illegal}, {127'd0, exp_ill});
        check("R9 no valid idle", {127'd0, out_valid}, '0);

        // Pseudo-random coverage of R3, R4, R5, R6, R7
        for (int k = 0; k < 200; k++) begin
            logic [127:0] ra, rb, rd;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            rd = {$urandom, $urandom, $urandom, $urandom};
            run("R3/R4/R5 random", ra, rb, rd, k % 3, k[2], k[3], k[4]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule